// File: doc/BRIEF.md
# TLB Exception Entry Controller

This block performs the processor-state updates that follow a memory-translation fault. There are three fault kinds: refill (no matching translation), invalid (a match that is not valid) and modified (a store to a clean page). When one of them is signalled, the block captures the faulting virtual address. It builds new values for the translation registers (bad-address, entry-high and context), picks the exception code and decides whether the return PC is saved. It also raises the exception-level write and computes the handler address from the exception base.

The block does not own the register file. It presents write strobes with their data, plus a one-cycle redirect with a target PC. The surrounding control-register file and fetch unit consume these. The outputs are registered, so every write and the redirect appear together in the cycle after the fault strobe. The caller supplies the current exception-level bit, the exception base and the current context register value, sampled in the same cycle as the fault.

Top module: `tlb_fault_entry`

## Requirements
- R1: After reset every strobe output is low and every data output, including the redirect PC and the exception code, is zero.
- R2: For fault kind refill (faultKind=0) or invalid (faultKind=1), the exception code is 2 when faultIsStore is low and 3 when it is high.
- R3: For fault kind modified (faultKind=2), the exception code is 1 regardless of faultIsStore.
- R4: A refill fault taken with exlIn low redirects to ebaseIn + 0x000.
- R5: A refill fault taken with exlIn high redirects to ebaseIn + 0x180. The exception-level value used is the one sampled with the fault, before the block's own exlWe takes effect.
- R6: Invalid and modified faults always redirect to ebaseIn + 0x180, whatever exlIn is.
- R7: On an accepted fault, badVAddrData equals the faulting address.
- R8: On an accepted fault, entryHiData holds faultAddr[31:13] in bits [31:13], faultAddr[12:11] in bits [12:11], zero in bits [10:8] and curAsid in bits [7:0].
- R9: On an accepted fault, contextData equals contextIn with bits [22:4] replaced by faultAddr[31:13].
- R10: epcWe pulses and epcData takes faultPc only when exlIn was low with the fault. When exlIn was high, epcWe stays low and epcData keeps its previous value.
- R11: badVAddrWe, entryHiWe, contextWe, causeWe, exlWe and redirectValid pulse together for exactly one cycle, in the cycle after an accepted fault strobe. In cycles with no accepted fault they are low.
- R12: A strobe with the unused kind faultKind=3 is ignored: no strobe rises and every data output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| faultValid | input | 1 | Fault strobe, one fault per cycle |
| faultKind | input | 2 | 0 refill, 1 invalid, 2 modified, 3 unused |
| faultIsStore | input | 1 | Faulting access was a store |
| faultAddr | input | 32 | Faulting virtual address |
| curAsid | input | 8 | Current address-space identifier |
| faultPc | input | 32 | PC of the faulting instruction |
| exlIn | input | 1 | Exception-level bit before this fault |
| ebaseIn | input | 32 | Exception base address |
| contextIn | input | 32 | Current context register value |
| badVAddrWe | output | 1 | Bad-address register write |
| badVAddrData | output | 32 | Bad-address write data |
| entryHiWe | output | 1 | Entry-high register write |
| entryHiData | output | 32 | Entry-high write data |
| contextWe | output | 1 | Context register write |
| contextData | output | 32 | Context write data |
| causeWe | output | 1 | Exception-code write |
| causeExcCode | output | 5 | Exception code |
| epcWe | output | 1 | Return-PC write |
| epcData | output | 32 | Return-PC write data |
| exlWe | output | 1 | Set exception-level bit |
| redirectValid | output | 1 | Fetch redirect |
| redirectPc | output | 32 | Handler address |

## Verification
Random faults cover every kind, both access directions and both exception-level values. This shows whether the code choice follows the direction only for refill and invalid faults, and whether the vector offset depends on the exception level only for refill. Random addresses, identifiers and context values separate the field placement in entry-high and context from a plain copy, and show that the untouched context bits are preserved. Directed cases add back-to-back faults, which catch strobes that stretch past one cycle or data captured from the wrong fault. They also add unused-kind strobes, whose outputs must stay frozen, and a nested fault, where the return PC must not move.

// File: rtl/tlb_fault_pkg.sv
package tlb_fault_pkg;

  typedef enum logic [1:0] {
    FK_REFILL   = 2'd0,
    FK_INVALID  = 2'd1,
    FK_MODIFIED = 2'd2,
    FK_UNUSED   = 2'd3
  } faultKind_e;

  localparam int EXC_W = 5;

  localparam logic [EXC_W-1:0] EXC_MODIFIED = 5'd1;
  localparam logic [EXC_W-1:0] EXC_LOAD     = 5'd2;
  localparam logic [EXC_W-1:0] EXC_STORE    = 5'd3;

  // Control-to-datapath strobe bundle, decoded in the fault cycle
  typedef struct packed {
    logic             capture;     // accept this fault
    logic             saveEpc;     // exception level was clear
    logic             generalVec;  // use the general vector offset
    logic [EXC_W-1:0] excCode;
  } entryCtrl_t;

endpackage

// File: rtl/tlb_fault_ctrl.sv
module tlb_fault_ctrl
  import tlb_fault_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             faultValid,
  input  logic [1:0]       faultKind,
  input  logic             faultIsStore,
  input  logic             exlIn,
  output entryCtrl_t       ctrlNow,
  output logic             regWePulse,
  output logic             epcWePulse,
  output logic [EXC_W-1:0] excCodeQ
);

  faultKind_e kind;
  logic       kindKnown;

  assign kind      = faultKind_e'(faultKind);
  assign kindKnown = (kind != FK_UNUSED);

  // Decode: the exception level is taken as sampled with the fault,
  // before this block's own exlWe can change it.
  always_comb begin
    ctrlNow            = '0;
    ctrlNow.capture    = faultValid && kindKnown;
    ctrlNow.saveEpc    = faultValid && kindKnown && !exlIn;
    ctrlNow.generalVec = !((kind == FK_REFILL) && !exlIn);
    unique case (kind)
      FK_MODIFIED: ctrlNow.excCode = EXC_MODIFIED;
      FK_REFILL,
      FK_INVALID:  ctrlNow.excCode = faultIsStore ? EXC_STORE : EXC_LOAD;
      default:     ctrlNow.excCode = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regWePulse <= 1'b0;
      epcWePulse <= 1'b0;
      excCodeQ   <= '0;
    end else begin
      regWePulse <= ctrlNow.capture;
      epcWePulse <= ctrlNow.saveEpc;
      if (ctrlNow.capture) begin
        excCodeQ <= ctrlNow.excCode;
      end
    end
  end

endmodule

// File: rtl/tlb_fault_dp.sv
module tlb_fault_dp
  import tlb_fault_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int ASID_W       = 8,
  parameter int VPN2_LSB     = 13,
  parameter int CTX_VPN_LSB  = 4,
  parameter logic [ADDR_W-1:0] GEN_VEC_OFF = 'h180
) (
  input  logic              clk,
  input  logic              rstN,
  input  entryCtrl_t        ctrlNow,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic [ASID_W-1:0] curAsid,
  input  logic [ADDR_W-1:0] faultPc,
  input  logic [ADDR_W-1:0] ebaseIn,
  input  logic [ADDR_W-1:0] contextIn,
  output logic [ADDR_W-1:0] badVAddrQ,
  output logic [ADDR_W-1:0] entryHiQ,
  output logic [ADDR_W-1:0] contextQ,
  output logic [ADDR_W-1:0] epcQ,
  output logic              redirectQ,
  output logic [ADDR_W-1:0] redirectPcQ
);

  localparam int VPN2_W = ADDR_W - VPN2_LSB;
  localparam int VPNX_W = 2;
  localparam int PAD_W  = VPN2_LSB - VPNX_W - ASID_W;

  logic [VPN2_W-1:0] vpn2;
  logic [ADDR_W-1:0] entryHiNext;
  logic [ADDR_W-1:0] contextNext;
  logic [ADDR_W-1:0] vectorNext;

  assign vpn2 = faultAddr[ADDR_W-1:VPN2_LSB];

  generate
    if (PAD_W > 0) begin : g_pad
      assign entryHiNext = {vpn2, faultAddr[VPN2_LSB-1 -: VPNX_W],
                            {PAD_W{1'b0}}, curAsid};
    end else begin : g_nopad
      assign entryHiNext = {vpn2, faultAddr[VPN2_LSB-1 -: VPNX_W], curAsid};
    end
  endgenerate

  always_comb begin
    contextNext = contextIn;
    contextNext[CTX_VPN_LSB +: VPN2_W] = vpn2;
  end

  assign vectorNext = ctrlNow.generalVec ? (ebaseIn + GEN_VEC_OFF) : ebaseIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      badVAddrQ   <= '0;
      entryHiQ    <= '0;
      contextQ    <= '0;
      epcQ        <= '0;
      redirectQ   <= 1'b0;
      redirectPcQ <= '0;
    end else begin
      redirectQ <= ctrlNow.capture;
      if (ctrlNow.capture) begin
        badVAddrQ   <= faultAddr;
        entryHiQ    <= entryHiNext;
        contextQ    <= contextNext;
        redirectPcQ <= vectorNext;
      end
      if (ctrlNow.saveEpc) begin
        epcQ <= faultPc;
      end
    end
  end

endmodule

// File: rtl/tlb_fault_entry.sv
module tlb_fault_entry
  import tlb_fault_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultValid,
  input  logic [1:0]        faultKind,
  input  logic              faultIsStore,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic [ASID_W-1:0] curAsid,
  input  logic [ADDR_W-1:0] faultPc,
  input  logic              exlIn,
  input  logic [ADDR_W-1:0] ebaseIn,
  input  logic [ADDR_W-1:0] contextIn,
  output logic              badVAddrWe,
  output logic [ADDR_W-1:0] badVAddrData,
  output logic              entryHiWe,
  output logic [ADDR_W-1:0] entryHiData,
  output logic              contextWe,
  output logic [ADDR_W-1:0] contextData,
  output logic              causeWe,
  output logic [4:0]        causeExcCode,
  output logic              epcWe,
  output logic [ADDR_W-1:0] epcData,
  output logic              exlWe,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectPc
);

  entryCtrl_t ctrlNow;
  logic       regWePulse;

  tlb_fault_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .faultValid   (faultValid),
    .faultKind    (faultKind),
    .faultIsStore (faultIsStore),
    .exlIn        (exlIn),
    .ctrlNow      (ctrlNow),
    .regWePulse   (regWePulse),
    .epcWePulse   (epcWe),
    .excCodeQ     (causeExcCode)
  );

  tlb_fault_dp #(
    .ADDR_W (ADDR_W),
    .ASID_W (ASID_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlNow     (ctrlNow),
    .faultAddr   (faultAddr),
    .curAsid     (curAsid),
    .faultPc     (faultPc),
    .ebaseIn     (ebaseIn),
    .contextIn   (contextIn),
    .badVAddrQ   (badVAddrData),
    .entryHiQ    (entryHiData),
    .contextQ    (contextData),
    .epcQ        (epcData),
    .redirectQ   (redirectValid),
    .redirectPcQ (redirectPc)
  );

  assign badVAddrWe = regWePulse;
  assign entryHiWe  = regWePulse;
  assign contextWe  = regWePulse;
  assign causeWe    = regWePulse;
  assign exlWe      = regWePulse;

endmodule

// File: rtl/tlb_fault_entry_chk.sv
module tlb_fault_entry_chk #(
  parameter int ADDR_W = 32,
  parameter int ASID_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              faultValid,
  input logic [1:0]        faultKind,
  input logic              faultIsStore,
  input logic [ADDR_W-1:0] faultAddr,
  input logic [ADDR_W-1:0] faultPc,
  input logic              exlIn,
  input logic [ADDR_W-1:0] ebaseIn,
  input logic              badVAddrWe,
  input logic [ADDR_W-1:0] badVAddrData,
  input logic [4:0]        causeExcCode,
  input logic              epcWe,
  input logic [ADDR_W-1:0] epcData,
  input logic              redirectValid,
  input logic [ADDR_W-1:0] redirectPc
);

  p_dir_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && $past(faultKind) != 2'd2)
      |-> causeExcCode == ($past(faultIsStore) ? 5'd3 : 5'd2));

  p_mod_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && $past(faultKind) == 2'd2) |-> causeExcCode == 5'd1);

  p_refill_base_r4: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && $past(faultKind) == 2'd0 && !$past(exlIn))
      |-> redirectPc == $past(ebaseIn));

  p_general_vec_r6: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && $past(faultKind) != 2'd0)
      |-> redirectPc == $past(ebaseIn) + 32'h180);

  p_badaddr_r7: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> badVAddrData == $past(faultAddr));

  p_epc_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    epcWe |-> (redirectValid && !$past(exlIn) && epcData == $past(faultPc)));

  p_epc_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !epcWe |=> (epcWe || $stable(epcData)));

  p_together_r11: assert property (@(posedge clk) disable iff (!rstN)
    badVAddrWe == redirectValid);

  p_unused_r12: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && faultKind == 2'd3) |=> !redirectValid);

endmodule

bind tlb_fault_entry tlb_fault_entry_chk #(
  .ADDR_W (ADDR_W),
  .ASID_W (ASID_W)
) u_chk (.*);

// File: tb/tb_tlb_fault_entry.sv
module tb_tlb_fault_entry;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        faultValid = 1'b0;
  logic [1:0]  faultKind = 2'd0;
  logic        faultIsStore = 1'b0;
  logic [31:0] faultAddr = '0;
  logic [7:0]  curAsid = '0;
  logic [31:0] faultPc = '0;
  logic        exlIn = 1'b0;
  logic [31:0] ebaseIn = '0;
  logic [31:0] contextIn = '0;
  logic        badVAddrWe, entryHiWe, contextWe, causeWe, epcWe, exlWe;
  logic        redirectValid;
  logic [31:0] badVAddrData, entryHiData, contextData, epcData, redirectPc;
  logic [4:0]  causeExcCode;

  int testCount = 0;
  int failCount = 0;
  int cycles    = 0;

  // expected model state
  logic        expValid;
  logic        expEpcWe;
  logic [4:0]  expCode;
  logic [31:0] expVec, expBad, expEhi, expCtx, expEpc;

  tlb_fault_entry dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= MAX_CYCLES) begin
      failCount = failCount + 1;
      testCount = testCount + 1;
      $display("FAIL watchdog: run exceeded %0d cycles", MAX_CYCLES);
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  function automatic logic [4:0] codeOf(logic [1:0] k, logic st);
    if (k == 2'd2) return 5'd1;
    return st ? 5'd3 : 5'd2;
  endfunction

  function automatic logic [31:0] vecOf(logic [1:0] k, logic x, logic [31:0] b);
    if (k == 2'd0 && !x) return b;
    return b + 32'h180;
  endfunction

  function automatic logic [31:0] ehiOf(logic [31:0] a, logic [7:0] asid);
    return {a[31:13], a[12:11], 3'b000, asid};
  endfunction

  function automatic logic [31:0] ctxOf(logic [31:0] c, logic [31:0] a);
    logic [31:0] r;
    r = c;
    r[22:4] = a[31:13];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount = testCount + 1;
    if (act !== exp) begin
      failCount = failCount + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic driveFault(input logic [1:0] k, input logic st, input logic [31:0] a,
                            input logic [7:0] asid, input logic [31:0] pc,
                            input logic x, input logic [31:0] b, input logic [31:0] c);
    faultValid = 1'b1; faultKind = k; faultIsStore = st; faultAddr = a;
    curAsid = asid; faultPc = pc; exlIn = x; ebaseIn = b; contextIn = c;
    if (k == 2'd3) begin
      expValid = 1'b0;   // R12: data keeps previous expected values
      expEpcWe = 1'b0;
    end else begin
      expValid = 1'b1;
      expCode  = codeOf(k, st);
      expVec   = vecOf(k, x, b);
      expBad   = a;
      expEhi   = ehiOf(a, asid);
      expCtx   = ctxOf(c, a);
      expEpcWe = !x;
      if (!x) expEpc = pc;
    end
  endtask

  task automatic checkOut(input logic [1:0] k);
    string codeReq, vecReq;
    codeReq = (k == 2'd2) ? "R3 code" : "R2 code";
    vecReq  = (k == 2'd0) ? "R4/R5 refill vector" : "R6 general vector";
    if (k == 2'd3) begin
      codeReq = "R12 code held";
      vecReq  = "R12 vector held";
    end
    chk("R11 redirectValid", {31'b0, redirectValid}, {31'b0, expValid});
    chk("R11 strobes", {26'b0, badVAddrWe, entryHiWe, contextWe, causeWe, exlWe, redirectValid},
        {26'b0, {6{expValid}}});
    chk(codeReq, {27'b0, causeExcCode}, {27'b0, expCode});
    chk(vecReq, redirectPc, expVec);
    chk("R7 badVAddr", badVAddrData, expBad);
    chk("R8 entryHi", entryHiData, expEhi);
    chk("R9 context", contextData, expCtx);
    chk("R10 epcWe", {31'b0, epcWe}, {31'b0, expEpcWe});
    chk("R10 epcData", epcData, expEpc);
  endtask

  task automatic idleCheck();
    faultValid = 1'b0;
    @(negedge clk);
    chk("R11 idle strobes", {25'b0, badVAddrWe, entryHiWe, contextWe, causeWe, epcWe, exlWe,
        redirectValid}, 32'd0);
  endtask

  task automatic oneFault(input logic [1:0] k, input logic st, input logic [31:0] a,
                          input logic [7:0] asid, input logic [31:0] pc,
                          input logic x, input logic [31:0] b, input logic [31:0] c);
    driveFault(k, st, a, asid, pc, x, b, c);
    @(negedge clk);
    checkOut(k);
    idleCheck();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    expValid = 0; expEpcWe = 0; expCode = 0;
    expVec = 0; expBad = 0; expEhi = 0; expCtx = 0; expEpc = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset strobes", {25'b0, badVAddrWe, entryHiWe, contextWe, causeWe, epcWe, exlWe,
        redirectValid}, 32'd0);
    chk("R1 reset data", badVAddrData | entryHiData | contextData | epcData | redirectPc,
        32'd0);
    chk("R1 reset code", {27'b0, causeExcCode}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {31'b0, redirectValid}, 32'd0);

    // Directed: R4 refill, exl clear, load
    oneFault(2'd0, 1'b0, 32'hDEAD_BEEF, 8'h5A, 32'h8000_1000, 1'b0, 32'h8000_0000, 32'hFFFF_FFFF);
    // R5 refill, exl set, store: vector general, EPC untouched (R10)
    oneFault(2'd0, 1'b1, 32'h1234_5678, 8'hA5, 32'h9000_0000, 1'b1, 32'h8000_0000, 32'h0);
    // R6 invalid with exl clear, store
    oneFault(2'd1, 1'b1, 32'hFFFF_E000, 8'hFF, 32'h0000_0040, 1'b0, 32'hBFC0_0200, 32'h1234_5678);
    // R3 modified, load flag ignored
    oneFault(2'd2, 1'b0, 32'h0000_1800, 8'h01, 32'h0000_0080, 1'b1, 32'h8000_1000, 32'hA5A5_A5A5);
    // R12 unused kind ignored
    oneFault(2'd3, 1'b1, 32'h5555_5555, 8'h33, 32'h7777_7777, 1'b0, 32'h1111_0000, 32'h2222_2222);

    // Back-to-back faults (R11)
    driveFault(2'd1, 1'b0, 32'hCAFE_F00D, 8'h10, 32'h4000_0004, 1'b0, 32'h8000_0000, 32'h0F0F_0F0F);
    @(negedge clk);
    checkOut(2'd1);
    driveFault(2'd0, 1'b1, 32'h0BAD_C0DE, 8'h20, 32'h4000_0008, 1'b1, 32'h8000_0000, 32'hF0F0_F0F0);
    @(negedge clk);
    checkOut(2'd0);
    driveFault(2'd3, 1'b0, 32'h0, 8'h0, 32'h0, 1'b0, 32'h0, 32'h0);
    @(negedge clk);
    checkOut(2'd3);
    idleCheck();

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      logic [1:0] k;
      k = 2'($urandom_range(0, 3));
      if (k == 2'd3 && ($urandom % 4) != 0) k = 2'd0;
      driveFault(k, 1'($urandom), $urandom, 8'($urandom), $urandom, 1'($urandom),
                 {$urandom, 12'h000} >> 12 << 12, $urandom);
      @(negedge clk);
      checkOut(k);
      if ($urandom % 2) idleCheck();
    end
    faultValid = 1'b0;
    idleCheck();

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule